// File: doc/BRIEF.md
# Tamper Monitor Security State Machine

This block holds the security condition of a battery-backed monitor. Up to ten tamper sources can report an event: voltage, clock, temperature, two external pins, a wire mesh, an external boot, a secure-controller alarm, a time-counter overflow and a monotonic-counter overflow. Each source passes only when its own bit in the tamper enable register is set. An event that passes latches a sticky status bit for its source and raises the failure flag. A raised failure flag freezes the time counter, so that the time of the violation is kept.

Two flags give three conditions. Non-valid is always set after a battery reset. Failure is set by any enabled event. Valid means that neither flag is set. Software can leave the failure condition only after a system reset has added non-valid to it. It must then disable the sources, clear their status bits, clear the failure flag and clear non-valid last. Write-once lock bits can freeze the enable register (soft or hard) and can stop a system reset from adding non-valid (failure hard lock). A soft lock is removed by a system reset. A hard lock is removed only by a battery reset.

The register port takes one write per cycle as a select plus a data word. A write takes effect at the next clock edge, and all outputs are registered.

Top module: `tamper_guard`

## Requirements
- R1: While `bat_rst` is high at a clock edge, non-valid becomes 1. Failure, every status bit, every enable bit, every lock bit, the interrupt enable and the interrupt all become 0.
- R2: At the edge after `evt_i[i]` is high while enable bit i is set, status bit i and the failure flag are both 1. An event on a disabled source changes neither of them.
- R3: `freeze_o` is high in exactly the cycles in which the failure flag is set.
- R4: While failure is set and non-valid is clear, a status write (select 2) changes no status bit, no failure flag and no non-valid flag.
- R5: A `sys_rst` cycle with failure set and the failure hard lock (lock bit 2) clear sets non-valid at the next edge. With the failure hard lock set, non-valid stays 0.
- R6: A status write (select 2) with data bit i set clears status bit i (i below 10) at the next edge, but only while non-valid is set.
- R7: A status write with data bit 10 set clears the failure flag only while non-valid is set and no status bit remains set whose enable bit is also set. Otherwise failure stays 1.
- R8: A status write with data bit 11 set clears non-valid only while failure is clear. Non-valid never clears while failure is set.
- R9: A write to the enable register (select 0, data bits 9..0) is ignored while the configuration soft lock (lock bit 0) or hard lock (lock bit 1) is set.
- R10: A write to select 1 sets each lock bit whose data bit is 1, and software can never clear a lock bit. `sys_rst` clears only lock bit 0. Writes are ignored in a `sys_rst` cycle.
- R11: `sv_irq_o` is a one-cycle pulse in the first cycle in which failure reads 1. It is raised only if the interrupt enable (select 3, data bit 0) is set. Further events while failure is already set raise no pulse.
- R12: An enabled event wins over a clear of its own status bit in the same cycle, so the bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| bat_rst | input | 1 | Synchronous active-high battery reset (full reset) |
| sys_rst | input | 1 | Synchronous active-high system reset pulse |
| evt_i | input | 10 | Raw tamper event inputs, one per source |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 enables, 1 locks, 2 status clear, 3 interrupt enable |
| wr_data | input | 12 | Write data |
| nonvalid_o | output | 1 | Non-valid flag |
| failure_o | output | 1 | Failure (security violation) flag |
| freeze_o | output | 1 | Time counter freeze |
| sv_irq_o | output | 1 | Security-violation interrupt pulse |
| evt_status_o | output | 10 | Latched event status bits |
| tamper_en_o | output | 10 | Tamper enable register |
| lock_o | output | 3 | Lock bits: 0 config soft, 1 config hard, 2 failure hard |
| irq_en_o | output | 1 | Interrupt enable |

## Verification
The bench goes after the recovery ordering. It tries to clear failure while enabled status bits remain, which a design that ignores the enable mask would let through and so leave the unit "valid" with a live tamper record. It also tries to clear non-valid before failure, which a wrong design would accept and leave the unit stuck in failure alone. It clears status while failure stands alone and issues a system reset under the failure hard lock, to catch a design that lets software or a system reset skip the battery path. An event and its own clear arrive in the same cycle, to catch a design where the clear wins and a tamper is silently lost. Repeated events after the first check that the interrupt does not fire twice.

// File: rtl/tamper_pkg.sv
package tamper_pkg;

    localparam int unsigned EVT_N  = 10;
    localparam int unsigned LOCK_W = 3;

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_LOCK   = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_IRQEN  = 2'd3
    } reg_sel_e;

    // bit 2 failure hard, bit 1 config hard, bit 0 config soft
    typedef struct packed {
        logic fail_hard;
        logic cfg_hard;
        logic cfg_soft;
    } lock_t;

    function automatic lock_t lock_merge(lock_t cur, logic [LOCK_W-1:0] w1s);
        return lock_t'(cur | w1s);
    endfunction

    function automatic logic cfg_frozen(lock_t l);
        return l.cfg_soft | l.cfg_hard;
    endfunction

endpackage

// File: rtl/tmp_cfg.sv
module tmp_cfg
    import tamper_pkg::*;
#(
    parameter int unsigned NUM_EVT = EVT_N
) (
    input  logic               clk,
    input  logic               bat_rst,
    input  logic               sys_rst,
    input  logic               wr_ok,
    input  reg_sel_e           sel,
    input  logic [NUM_EVT+1:0] wdata,
    output logic [NUM_EVT-1:0] en_q,
    output lock_t              lock_q,
    output logic               ien_q
);

    always_ff @(posedge clk) begin
        if (bat_rst) begin
            en_q   <= '0;
            lock_q <= '0;
            ien_q  <= 1'b0;
        end else begin
            if (sys_rst) begin
                lock_q.cfg_soft <= 1'b0;
            end else if (wr_ok && sel == SEL_LOCK) begin
                lock_q <= lock_merge(lock_q, wdata[LOCK_W-1:0]);
            end
            if (wr_ok && sel == SEL_ENABLE && !cfg_frozen(lock_q)) begin
                en_q <= wdata[NUM_EVT-1:0];
            end
            if (wr_ok && sel == SEL_IRQEN) begin
                ien_q <= wdata[0];
            end
        end
    end

    p_cfg_hard_sticky_r10: assert property (@(posedge clk) disable iff (bat_rst)
        lock_q.cfg_hard |=> lock_q.cfg_hard);
    p_fail_hard_sticky_r10: assert property (@(posedge clk) disable iff (bat_rst)
        lock_q.fail_hard |=> lock_q.fail_hard);
    p_soft_kept_r10: assert property (@(posedge clk) disable iff (bat_rst)
        (lock_q.cfg_soft && !sys_rst) |=> lock_q.cfg_soft);
    p_en_frozen_r9: assert property (@(posedge clk) disable iff (bat_rst)
        cfg_frozen(lock_q) |=> $stable(en_q));

endmodule

// File: rtl/tmp_evt_bank.sv
module tmp_evt_bank
    import tamper_pkg::*;
#(
    parameter int unsigned NUM_EVT = EVT_N
) (
    input  logic               clk,
    input  logic               bat_rst,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [NUM_EVT-1:0] en_i,
    input  logic [NUM_EVT-1:0] clr_i,
    input  logic               nonvalid_i,
    output logic [NUM_EVT-1:0] st_q,
    output logic               hit_o
);

    assign hit_o = |(evt_i & en_i);

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_src
        logic bit_q;

        always_ff @(posedge clk) begin
            if (bat_rst) begin
                bit_q <= 1'b0;
            end else if (evt_i[i] && en_i[i]) begin
                bit_q <= 1'b1;
            end else if (clr_i[i] && nonvalid_i) begin
                bit_q <= 1'b0;
            end
        end

        assign st_q[i] = bit_q;

        p_evt_latch_r2: assert property (@(posedge clk) disable iff (bat_rst)
            (evt_i[i] && en_i[i]) |=> st_q[i]);
        p_clr_needs_nv_r6: assert property (@(posedge clk) disable iff (bat_rst)
            (st_q[i] && !nonvalid_i) |=> st_q[i]);
    end

endmodule

// File: rtl/tmp_sec_state.sv
module tmp_sec_state
    import tamper_pkg::*;
#(
    parameter int unsigned NUM_EVT = EVT_N
) (
    input  logic               clk,
    input  logic               bat_rst,
    input  logic               sys_rst,
    input  logic               hit_i,
    input  logic [NUM_EVT-1:0] st_i,
    input  logic [NUM_EVT-1:0] en_i,
    input  logic               sv_clr_i,
    input  logic               nv_clr_i,
    input  logic               fail_hard_i,
    input  logic               ien_i,
    output logic               svf_q,
    output logic               nv_q,
    output logic               irq_q
);

    logic armed;
    assign armed = |(st_i & en_i);

    always_ff @(posedge clk) begin
        if (bat_rst) begin
            svf_q <= 1'b0;
            nv_q  <= 1'b1;
            irq_q <= 1'b0;
        end else begin
            if (hit_i) begin
                svf_q <= 1'b1;
            end else if (sv_clr_i && nv_q && !armed) begin
                svf_q <= 1'b0;
            end

            if (sys_rst && svf_q && !fail_hard_i) begin
                nv_q <= 1'b1;
            end else if (nv_clr_i && !svf_q && !hit_i) begin
                nv_q <= 1'b0;
            end

            irq_q <= ien_i && hit_i && !svf_q;
        end
    end

    p_fail_alone_holds_r4: assert property (@(posedge clk) disable iff (bat_rst)
        (svf_q && !nv_q) |=> svf_q);
    p_nv_promote_r5: assert property (@(posedge clk) disable iff (bat_rst)
        (sys_rst && svf_q && !fail_hard_i) |=> nv_q);
    p_armed_blocks_r7: assert property (@(posedge clk) disable iff (bat_rst)
        (svf_q && armed) |=> svf_q);
    p_nv_last_r8: assert property (@(posedge clk) disable iff (bat_rst)
        (nv_q && svf_q) |=> nv_q);
    p_irq_single_r11: assert property (@(posedge clk) disable iff (bat_rst)
        irq_q |=> !irq_q);
    p_irq_on_rise_r11: assert property (@(posedge clk) disable iff (bat_rst)
        irq_q |-> $rose(svf_q));

endmodule

// File: rtl/tamper_guard.sv
module tamper_guard
    import tamper_pkg::*;
#(
    parameter int unsigned NUM_EVT = EVT_N
) (
    input  logic               clk,
    input  logic               bat_rst,
    input  logic               sys_rst,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [NUM_EVT+1:0] wr_data,
    output logic               nonvalid_o,
    output logic               failure_o,
    output logic               freeze_o,
    output logic               sv_irq_o,
    output logic [NUM_EVT-1:0] evt_status_o,
    output logic [NUM_EVT-1:0] tamper_en_o,
    output logic [LOCK_W-1:0]  lock_o,
    output logic               irq_en_o
);

    localparam int unsigned SV_BIT = NUM_EVT;
    localparam int unsigned NV_BIT = NUM_EVT + 1;

    reg_sel_e           sel;
    logic               wr_ok;
    logic               stat_wr;
    logic [NUM_EVT-1:0] en_q;
    logic [NUM_EVT-1:0] st_q;
    logic [NUM_EVT-1:0] clr_vec;
    lock_t              lock_q;
    logic               ien_q;
    logic               hit;
    logic               svf_q;
    logic               nv_q;
    logic               irq_q;

    assign sel     = reg_sel_e'(wr_sel);
    assign wr_ok   = wr_en && !sys_rst;
    assign stat_wr = wr_ok && (sel == SEL_STATUS);
    assign clr_vec = stat_wr ? wr_data[NUM_EVT-1:0] : '0;

    tmp_cfg #(.NUM_EVT(NUM_EVT)) u_cfg (
        .clk     (clk),
        .bat_rst (bat_rst),
        .sys_rst (sys_rst),
        .wr_ok   (wr_ok),
        .sel     (sel),
        .wdata   (wr_data),
        .en_q    (en_q),
        .lock_q  (lock_q),
        .ien_q   (ien_q)
    );

    tmp_evt_bank #(.NUM_EVT(NUM_EVT)) u_bank (
        .clk        (clk),
        .bat_rst    (bat_rst),
        .evt_i      (evt_i),
        .en_i       (en_q),
        .clr_i      (clr_vec),
        .nonvalid_i (nv_q),
        .st_q       (st_q),
        .hit_o      (hit)
    );

    tmp_sec_state #(.NUM_EVT(NUM_EVT)) u_state (
        .clk         (clk),
        .bat_rst     (bat_rst),
        .sys_rst     (sys_rst),
        .hit_i       (hit),
        .st_i        (st_q),
        .en_i        (en_q),
        .sv_clr_i    (stat_wr && wr_data[SV_BIT]),
        .nv_clr_i    (stat_wr && wr_data[NV_BIT]),
        .fail_hard_i (lock_q.fail_hard),
        .ien_i       (ien_q),
        .svf_q       (svf_q),
        .nv_q        (nv_q),
        .irq_q       (irq_q)
    );

    assign nonvalid_o   = nv_q;
    assign failure_o    = svf_q;
    assign freeze_o     = svf_q;
    assign sv_irq_o     = irq_q;
    assign evt_status_o = st_q;
    assign tamper_en_o  = en_q;
    assign lock_o       = lock_q;
    assign irq_en_o     = ien_q;

    p_status_implies_fail_r2: assert property (@(posedge clk) disable iff (bat_rst)
        (hit && !sys_rst) |=> (failure_o && |evt_status_o));

endmodule

// File: tb/sim_tamper_guard.sv
`timescale 1ns/1ps
module sim_tamper_guard;

    logic        clk = 1'b0;
    logic        bat_rst = 1'b1;
    logic        sys_rst = 1'b0;
    logic [9:0]  evt_i = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [11:0] wr_data = '0;
    logic        nonvalid_o, failure_o, freeze_o, sv_irq_o, irq_en_o;
    logic [9:0]  evt_status_o, tamper_en_o;
    logic [2:0]  lock_o;

    int compared = 0;
    int mismatched = 0;
    bit started = 0;

    always #2.5 clk = ~clk;

    tamper_guard u0 (
        .clk(clk), .bat_rst(bat_rst), .sys_rst(sys_rst), .evt_i(evt_i),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .nonvalid_o(nonvalid_o), .failure_o(failure_o), .freeze_o(freeze_o),
        .sv_irq_o(sv_irq_o), .evt_status_o(evt_status_o), .tamper_en_o(tamper_en_o),
        .lock_o(lock_o), .irq_en_o(irq_en_o)
    );

    // behavioural reference, written from the requirements
    bit       m_nv, m_fail, m_irq, m_ien;
    bit [9:0] m_st, m_en;
    bit [2:0] m_lk;

    always @(posedge clk) begin
        bit       hit, armed, wr;
        bit [9:0] ns;
        started = 1;
        if (bat_rst) begin
            m_nv = 1; m_fail = 0; m_irq = 0; m_ien = 0; m_st = 0; m_en = 0; m_lk = 0;
        end else begin
            hit   = (evt_i & m_en) != 0;
            armed = (m_st & m_en) != 0;
            wr    = wr_en && !sys_rst;
            ns = m_st;
            for (int i = 0; i < 10; i++) begin
                if (evt_i[i] && m_en[i]) ns[i] = 1;
                else if (wr && wr_sel == 2 && wr_data[i] && m_nv) ns[i] = 0;
            end
            m_irq = m_ien && hit && !m_fail;
            if (sys_rst && m_fail && !m_lk[2]) m_nv = 1;
            else if (wr && wr_sel == 2 && wr_data[11] && !m_fail && !hit) m_nv = 0;
            if (hit) m_fail = 1;
            else if (wr && wr_sel == 2 && wr_data[10] && (m_nv || (sys_rst && m_fail && !m_lk[2] && 0)) && !armed) m_fail = 0;
            if (wr && wr_sel == 0 && !m_lk[0] && !m_lk[1]) m_en = wr_data[9:0];
            if (wr && wr_sel == 3) m_ien = wr_data[0];
            if (sys_rst) m_lk[0] = 0;
            else if (wr && wr_sel == 1) m_lk = m_lk | wr_data[2:0];
            m_st = ns;
        end
    end

    task automatic cmp(string tag, int got, int exp);
        compared++;
        if (got != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            cmp("R8 model nonvalid", nonvalid_o, m_nv);
            cmp("R2 model failure", failure_o, m_fail);
            cmp("R3 model freeze", freeze_o, m_fail);
            cmp("R11 model irq", sv_irq_o, m_irq);
            cmp("R6 model status", evt_status_o, m_st);
            cmp("R9 model enables", tamper_en_o, m_en);
            cmp("R10 model locks", lock_o, m_lk);
            cmp("R11 model irq enable", irq_en_o, m_ien);
        end
    end

    task automatic wr(input logic [1:0] s, input logic [11:0] d);
        wr_sel = s; wr_data = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic pulse_evt(input logic [9:0] m);
        evt_i = m;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic pulse_sys();
        sys_rst = 1;
        @(negedge clk);
        sys_rst = 0;
    endtask

    initial begin
        #(5.0 * 100000);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        bat_rst = 0;
        // R1 reset state
        cmp("R1 nonvalid", nonvalid_o, 1);
        cmp("R1 failure", failure_o, 0);
        cmp("R1 locks", lock_o, 0);
        cmp("R1 enables", tamper_en_o, 0);
        wr(2, 12'h800);
        cmp("R8 nv clear in valid path", nonvalid_o, 0);
        pulse_evt(10'h008);
        cmp("R2 disabled event ignored", evt_status_o, 0);
        cmp("R2 disabled event no fail", failure_o, 0);
        wr(3, 12'h001);
        wr(0, 12'h3FF);
        pulse_evt(10'h020);
        cmp("R2 status set", evt_status_o, 10'h020);
        cmp("R2 failure set", failure_o, 1);
        cmp("R3 freeze", freeze_o, 1);
        cmp("R11 irq pulse", sv_irq_o, 1);
        @(negedge clk);
        cmp("R11 irq drops", sv_irq_o, 0);
        pulse_evt(10'h004);
        cmp("R11 no second irq", sv_irq_o, 0);
        wr(2, 12'hFFF);
        cmp("R4 status kept", evt_status_o, 10'h024);
        cmp("R4 failure kept", failure_o, 1);
        cmp("R4 nonvalid kept", nonvalid_o, 0);
        pulse_sys();
        cmp("R5 nv promoted", nonvalid_o, 1);
        evt_i = 10'h002; wr(2, 12'h002); evt_i = '0;
        cmp("R12 event wins", evt_status_o, 10'h026);
        wr(2, 12'h400);
        cmp("R7 armed blocks clear", failure_o, 1);
        wr(2, 12'h800);
        cmp("R8 nv held under failure", nonvalid_o, 1);
        wr(1, 12'h001);
        wr(0, 12'h000);
        cmp("R9 soft lock blocks enables", tamper_en_o, 10'h3FF);
        pulse_sys();
        cmp("R10 sys reset drops soft lock", lock_o, 0);
        wr(0, 12'h000);
        wr(2, 12'h3FF);
        cmp("R6 status cleared", evt_status_o, 0);
        wr(2, 12'h400);
        cmp("R7 failure cleared", failure_o, 0);
        cmp("R3 freeze released", freeze_o, 0);
        wr(2, 12'h800);
        cmp("R8 nv cleared last", nonvalid_o, 0);
        wr(0, 12'h001);
        wr(1, 12'h006);
        wr(1, 12'h000);
        cmp("R10 locks sticky", lock_o, 3'b110);
        wr(0, 12'h3FF);
        cmp("R9 hard lock blocks enables", tamper_en_o, 10'h001);
        pulse_evt(10'h001);
        cmp("R2 failure again", failure_o, 1);
        pulse_sys();
        cmp("R5 fail hard lock keeps nv low", nonvalid_o, 0);
        cmp("R10 hard locks survive sys reset", lock_o, 3'b110);
        pulse_evt(10'h002);
        cmp("R2 disabled source not latched", evt_status_o, 10'h001);
        bat_rst = 1;
        repeat (2) @(negedge clk);
        bat_rst = 0;
        cmp("R1 battery reset nonvalid", nonvalid_o, 1);
        cmp("R1 battery reset locks", lock_o, 0);
        cmp("R1 battery reset status", evt_status_o, 0);
        cmp("R1 battery reset failure", failure_o, 0);
        repeat (3) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule